// File: doc/BRIEF.md
# Reload Interface Protocol Checker

A passive monitor that sits beside a cache-reload return path and a request channel, and flags timing violations on the reload sideband. A "data coming" early strobe announces a return; the checker then requires the "reload valid" strobe on the cycle right after it. Each valid strobe that meets such an expectation in turn requires a data beat exactly two cycles later. The qualifiers presented with a matching valid strobe (tag, inter-thread-transfer flag, quadword index, critical-quadword flag) are latched and brought out.

Expectations are held as due-cycle timestamps in small FIFOs, taken against a free-running cycle counter, so that overlapping back-to-back returns are tracked without a state machine per transfer. In the same cycles the checker screens instruction-fetch requests against a set of programmable, individually enabled forbidden address windows. All error outputs are sticky until reset. A counter reports the data beats that arrived on schedule.

Top module: `reload_proto_chk`

## Requirements
- R1: While and after reset, every error flag, the beat counter and all captured qualifiers read zero.
- R2: A coming strobe sampled at edge t requires valid_i high at edge t+1; if it is low, err_miss_valid_o is high from edge t+1 onward.
- R3: A valid strobe that meets an expectation latches tag_i, comm_i, qw_i and crit_i; the cap_* outputs show them after that edge.
- R4: A valid strobe that meets an expectation at edge t requires beat_i high at edge t+2; if it is low, err_miss_beat_o is high from edge t+2 onward.
- R5: Each beat that meets an expectation adds one to beat_cnt_o at that edge.
- R6: A valid strobe or a beat with no expectation due in its cycle is ignored: captures, beat count and error flags keep their values.
- R7: A request with req_type_i 8'h00 (fetch) whose address lies in [lo, hi] inclusive of any range whose enable bit is set raises err_bad_fetch_o; type 8'h08 (load), type 8'h20 (store), and disabled ranges never do.
- R8: A push into a full expectation FIFO sets err_ovf_o; with a depth of 4 or more, legal back-to-back traffic never sets it.
- R9: Every error flag, once set, stays set until rst_ni is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| coming_i | input | 1 | Early strobe announcing a return |
| valid_i | input | 1 | Reload valid strobe qualifying the sideband fields |
| tag_i | input | TAG_W | Return tag |
| comm_i | input | 1 | Inter-thread transfer flag |
| qw_i | input | 2 | Quadword index of the beat |
| crit_i | input | 1 | Critical quadword flag |
| beat_i | input | 1 | Data beat present |
| req_i | input | 1 | Request valid |
| req_type_i | input | 8 | Request type code |
| req_addr_i | input | AW | Request address |
| rng_lo_i | input | N_RANGE*AW | Lower bounds of forbidden windows, window g at bits g*AW |
| rng_hi_i | input | N_RANGE*AW | Upper bounds of forbidden windows |
| rng_en_i | input | N_RANGE | Per-window enable |
| err_miss_valid_o | output | 1 | Sticky: expected valid strobe absent |
| err_miss_beat_o | output | 1 | Sticky: expected data beat absent |
| err_bad_fetch_o | output | 1 | Sticky: fetch into forbidden window |
| err_ovf_o | output | 1 | Sticky: expectation FIFO overflow |
| beat_cnt_o | output | CNT_W | Count of beats on schedule |
| cap_tag_o | output | TAG_W | Latched tag |
| cap_comm_o | output | 1 | Latched transfer flag |
| cap_qw_o | output | 2 | Latched quadword index |
| cap_crit_o | output | 1 | Latched critical flag |

## Verification
A missing valid strobe shows on err_miss_valid_o at the edge one cycle after the coming strobe, a missing beat on err_miss_beat_o two edges after the matching valid, and a forbidden fetch on err_bad_fetch_o at the edge after the request; captures and the beat count move at the edge that samples the triggering strobe. The bench model keeps absolute due cycles in queues, updates on each rising edge from the same sampled inputs, and compares every output a quarter period after that edge, so each result is judged in the exact cycle it is due. Directed checks after each scenario pin down the boundary cases of the windows and the ignored strobes.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam logic [7:0] TT_FETCH = 8'h00;
  localparam logic [7:0] TT_LOAD  = 8'h08;
  localparam logic [7:0] TT_STORE = 8'h20;
  localparam int VALID_LAG = 1;
  localparam int BEAT_LAG  = 2;
endpackage

// File: rtl/rlc_ts_fifo.sv
module rlc_ts_fifo #(
  parameter int DEPTH = 4,
  parameter int TS_W  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [TS_W-1:0] push_ts_i,
  input  logic            pop_i,
  input  logic [TS_W-1:0] now_i,
  output logic            due_o,
  output logic            ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TS_W-1:0]  ts_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty, do_pop, do_push;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && (!full || do_pop);
  assign ovf_o   = push_i && full && !do_pop;
  assign due_o   = !empty && (ts_q[rd_q] == now_i);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             ts_q[g] <= '0;
      else if (do_push && wr_q == PTR_W'(g))   ts_q[g] <= push_ts_i;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R8
  AST_DUE_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_o |-> pop_i); // R2
endmodule

// File: rtl/rlc_range_match.sv
module rlc_range_match #(
  parameter int N_RANGE = 4,
  parameter int AW      = 32
) (
  input  logic [AW-1:0]         addr_i,
  input  logic [N_RANGE*AW-1:0] lo_i,
  input  logic [N_RANGE*AW-1:0] hi_i,
  input  logic [N_RANGE-1:0]    en_i,
  output logic                  hit_o
);
  logic [N_RANGE-1:0] hit;

  for (genvar g = 0; g < N_RANGE; g++) begin : g_win
    assign hit[g] = en_i[g] && (addr_i >= lo_i[g*AW +: AW]) && (addr_i <= hi_i[g*AW +: AW]);
  end

  assign hit_o = |hit;
endmodule

// File: rtl/reload_proto_chk.sv
module reload_proto_chk
  import rlc_pkg::*;
#(
  parameter int TAG_W   = 5,
  parameter int AW      = 32,
  parameter int N_RANGE = 4,
  parameter int DEPTH   = 4,
  parameter int TS_W    = 8,
  parameter int CNT_W   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  coming_i,
  input  logic                  valid_i,
  input  logic [TAG_W-1:0]      tag_i,
  input  logic                  comm_i,
  input  logic [1:0]            qw_i,
  input  logic                  crit_i,
  input  logic                  beat_i,
  input  logic                  req_i,
  input  logic [7:0]            req_type_i,
  input  logic [AW-1:0]         req_addr_i,
  input  logic [N_RANGE*AW-1:0] rng_lo_i,
  input  logic [N_RANGE*AW-1:0] rng_hi_i,
  input  logic [N_RANGE-1:0]    rng_en_i,
  output logic                  err_miss_valid_o,
  output logic                  err_miss_beat_o,
  output logic                  err_bad_fetch_o,
  output logic                  err_ovf_o,
  output logic [CNT_W-1:0]      beat_cnt_o,
  output logic [TAG_W-1:0]      cap_tag_o,
  output logic                  cap_comm_o,
  output logic [1:0]            cap_qw_o,
  output logic                  cap_crit_o
);
  localparam logic [TS_W-1:0] V_LAG = TS_W'(VALID_LAG);
  localparam logic [TS_W-1:0] B_LAG = TS_W'(BEAT_LAG);

  logic [TS_W-1:0] now_q;
  logic            v_due, v_ovf, d_due, d_ovf;
  logic            v_hit, rng_hit, fetch_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + TS_W'(1);
  end

  // coming -> valid expectations
  rlc_ts_fifo #(.DEPTH(DEPTH), .TS_W(TS_W)) u_vq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (coming_i),
    .push_ts_i (now_q + V_LAG),
    .pop_i     (v_due),
    .now_i     (now_q),
    .due_o     (v_due),
    .ovf_o     (v_ovf)
  );

  assign v_hit = v_due && valid_i;

  // valid -> beat expectations
  rlc_ts_fifo #(.DEPTH(DEPTH), .TS_W(TS_W)) u_dq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (v_hit),
    .push_ts_i (now_q + B_LAG),
    .pop_i     (d_due),
    .now_i     (now_q),
    .due_o     (d_due),
    .ovf_o     (d_ovf)
  );

  rlc_range_match #(.N_RANGE(N_RANGE), .AW(AW)) u_rng (
    .addr_i (req_addr_i),
    .lo_i   (rng_lo_i),
    .hi_i   (rng_hi_i),
    .en_i   (rng_en_i),
    .hit_o  (rng_hit)
  );

  assign fetch_hit = req_i && (req_type_i == TT_FETCH) && rng_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_miss_valid_o <= 1'b0;
      err_miss_beat_o  <= 1'b0;
      err_bad_fetch_o  <= 1'b0;
      err_ovf_o        <= 1'b0;
    end else begin
      if (v_due && !valid_i) err_miss_valid_o <= 1'b1;
      if (d_due && !beat_i)  err_miss_beat_o  <= 1'b1;
      if (fetch_hit)         err_bad_fetch_o  <= 1'b1;
      if (v_ovf || d_ovf)    err_ovf_o        <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               beat_cnt_o <= '0;
    else if (d_due && beat_i)  beat_cnt_o <= beat_cnt_o + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_tag_o  <= '0;
      cap_comm_o <= 1'b0;
      cap_qw_o   <= '0;
      cap_crit_o <= 1'b0;
    end else if (v_hit) begin
      cap_tag_o  <= tag_i;
      cap_comm_o <= comm_i;
      cap_qw_o   <= qw_i;
      cap_crit_o <= crit_i;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_due && !valid_i) |=> err_miss_valid_o); // R2
  AST_CAP_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_due && valid_i) |=> (cap_tag_o == $past(tag_i) && cap_qw_o == $past(qw_i))); // R3
  AST_BEAT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_due && !beat_i) |=> err_miss_beat_o); // R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_due && beat_i) |=> beat_cnt_o == $past(beat_cnt_o) + CNT_W'(1)); // R5
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(d_due && beat_i) |=> $stable(beat_cnt_o)); // R6
  AST_BAD_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_hit |=> err_bad_fetch_o); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_ovf || d_ovf) |=> err_ovf_o); // R8
  AST_STICKY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_miss_valid_o |=> err_miss_valid_o); // R9
  AST_STICKY_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_bad_fetch_o |=> err_bad_fetch_o); // R9
endmodule

// File: tb/sim_reload_proto_chk.sv
module sim_reload_proto_chk;
  localparam int TAG_W = 5, AW = 32, NR = 4, DEPTH = 4, CNT_W = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic coming_i = 0, valid_i = 0, comm_i = 0, crit_i = 0, beat_i = 0, req_i = 0;
  logic [TAG_W-1:0] tag_i = '0;
  logic [1:0] qw_i = '0;
  logic [7:0] req_type_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [NR*AW-1:0] rng_lo_i, rng_hi_i;
  logic [NR-1:0] rng_en_i;
  logic e_mv, e_mb, e_bf, e_ov, cap_comm_o, cap_crit_o;
  logic [CNT_W-1:0] beat_cnt_o;
  logic [TAG_W-1:0] cap_tag_o;
  logic [1:0] cap_qw_o;

  always #4 clk_i = ~clk_i;

  reload_proto_chk #(.TAG_W(TAG_W), .AW(AW), .N_RANGE(NR), .DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk_i, .rst_ni, .coming_i, .valid_i, .tag_i, .comm_i, .qw_i, .crit_i, .beat_i,
    .req_i, .req_type_i, .req_addr_i, .rng_lo_i, .rng_hi_i, .rng_en_i,
    .err_miss_valid_o(e_mv), .err_miss_beat_o(e_mb), .err_bad_fetch_o(e_bf), .err_ovf_o(e_ov),
    .beat_cnt_o, .cap_tag_o, .cap_comm_o, .cap_qw_o, .cap_crit_o);

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int cyc = 0, qv[$], qd[$];
  bit m_mv, m_mb, m_bf, m_ov, m_comm, m_crit;
  int m_cnt, m_tag, m_qw;

  function automatic bit in_bad(input logic [AW-1:0] a);
    for (int g = 0; g < NR; g++)
      if (rng_en_i[g] && a >= rng_lo_i[g*AW +: AW] && a <= rng_hi_i[g*AW +: AW]) return 1;
    return 0;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      qv.delete(); qd.delete();
      {m_mv, m_mb, m_bf, m_ov, m_comm, m_crit} = '0;
      m_cnt = 0; m_tag = 0; m_qw = 0;
    end else begin
      bit vp, dp;
      vp = 0; dp = 0;
      if (qv.size() > 0 && qv[0] == cyc) begin
        void'(qv.pop_front()); vp = 1;
        if (valid_i) begin
          m_tag = tag_i; m_comm = comm_i; m_qw = qw_i; m_crit = crit_i;
          if (qd.size() >= DEPTH) m_ov = 1; else qd.push_back(cyc + 2);
        end else m_mv = 1;
      end
      if (qd.size() > 0 && qd[0] == cyc && !(vp && qd[$] == cyc + 2 && qd.size() == 1)) begin
        void'(qd.pop_front()); dp = 1;
        if (beat_i) m_cnt++; else m_mb = 1;
      end
      if (coming_i) begin
        if (qv.size() >= DEPTH) m_ov = 1; else qv.push_back(cyc + 1);
      end
      if (req_i && req_type_i == 8'h00 && in_bad(req_addr_i)) m_bf = 1;
    end
    cyc++;
    #2;
    chk(e_mv == m_mv, "R2 miss_valid", e_mv, m_mv);
    chk(e_mb == m_mb, "R4 miss_beat", e_mb, m_mb);
    chk(beat_cnt_o == CNT_W'(m_cnt), "R5 beat_cnt", beat_cnt_o, m_cnt);
    chk(cap_tag_o == TAG_W'(m_tag) && cap_qw_o == 2'(m_qw) && cap_comm_o == m_comm && cap_crit_o == m_crit,
        "R3 capture", {cap_tag_o, cap_comm_o, cap_qw_o, cap_crit_o}, {5'(m_tag), m_comm, 2'(m_qw), m_crit});
    chk(e_bf == m_bf, "R7 bad_fetch", e_bf, m_bf);
    chk(e_ov == m_ov, "R8 overflow", e_ov, m_ov);
  end

  task automatic drv(input bit c, input bit v, input bit b, input int tg = 0,
                     input bit cm = 0, input int q = 0, input bit cr = 0);
    coming_i = c; valid_i = v; beat_i = b;
    tag_i = TAG_W'(tg); comm_i = cm; qw_i = 2'(q); crit_i = cr;
    @(negedge clk_i);
    coming_i = 0; valid_i = 0; beat_i = 0;
  endtask

  task automatic req(input logic [7:0] tt, input logic [AW-1:0] a);
    req_i = 1; req_type_i = tt; req_addr_i = a;
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rng_lo_i = '0; rng_hi_i = '0;
    rng_lo_i[0*AW +: AW] = 32'h1000; rng_hi_i[0*AW +: AW] = 32'h1FFF;
    rng_lo_i[1*AW +: AW] = 32'h8000; rng_hi_i[1*AW +: AW] = 32'h8000;
    rng_lo_i[2*AW +: AW] = 32'h4000; rng_hi_i[2*AW +: AW] = 32'h4FFF;
    rng_en_i = 4'b0011;
    repeat (3) @(negedge clk_i);
    chk({e_mv, e_mb, e_bf, e_ov, beat_cnt_o, cap_tag_o} == '0, "R1 reset", beat_cnt_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // single return
    drv(1, 0, 0);
    drv(0, 1, 0, 5, 1, 2, 1);
    drv(0, 0, 0);
    drv(0, 0, 1);
    drv(0, 0, 0);
    chk(beat_cnt_o == 1, "R5 single", beat_cnt_o, 1);
    chk(cap_tag_o == 5 && cap_qw_o == 2 && cap_comm_o && cap_crit_o, "R3 single", cap_tag_o, 5);

    // four back-to-back beats
    drv(1, 0, 0);
    drv(1, 1, 0, 0, 0, 0, 1);
    drv(1, 1, 0, 1, 0, 1, 0);
    drv(1, 1, 1, 2, 0, 2, 0);
    drv(0, 1, 1, 3, 0, 3, 0);
    drv(0, 0, 1);
    drv(0, 0, 1);
    drv(0, 0, 0);
    chk(beat_cnt_o == 5, "R5 back-to-back", beat_cnt_o, 5);
    chk(cap_tag_o == 3 && cap_qw_o == 3, "R3 last qualifiers", cap_tag_o, 3);
    chk(!e_ov && !e_mv && !e_mb, "R8 no overflow", e_ov, 0);

    // stray strobes
    drv(0, 1, 0, 9, 1, 1, 1);
    drv(0, 0, 0);
    drv(0, 0, 1);
    drv(0, 0, 0);
    chk(cap_tag_o == 3 && beat_cnt_o == 5 && !e_mv && !e_mb, "R6 stray ignored", cap_tag_o, 3);

    // request screening
    req(8'h00, 32'h0FFF);
    req(8'h08, 32'h1000);
    req(8'h20, 32'h1800);
    req(8'h00, 32'h4800);
    req(8'h00, 32'h8001);
    chk(!e_bf, "R7 outside or not fetch", e_bf, 0);
    req(8'h00, 32'h8000);
    chk(e_bf, "R7 single-address window", e_bf, 1);
    drv(1, 1, 0); drv(0, 1, 0); drv(0, 0, 0); drv(0, 0, 1);
    chk(e_bf, "R9 fetch flag sticky", e_bf, 1);
    do_reset();
    chk(!e_bf && beat_cnt_o == 0, "R1 reset clears", e_bf, 0);
    req(8'h00, 32'h1FFF);
    chk(e_bf, "R7 upper bound", e_bf, 1);
    do_reset();
    req(8'h00, 32'h1000);
    chk(e_bf, "R7 lower bound", e_bf, 1);
    do_reset();

    // missing valid
    drv(1, 0, 0);
    drv(0, 0, 0);
    chk(e_mv && !e_mb, "R2 missing valid", e_mv, 1);
    drv(1, 0, 0); drv(0, 1, 0, 4); drv(0, 0, 0); drv(0, 0, 1);
    chk(e_mv && beat_cnt_o == 1, "R9 valid flag sticky", e_mv, 1);
    do_reset();

    // missing beat
    drv(1, 0, 0);
    drv(0, 1, 0, 7);
    drv(0, 0, 0);
    chk(!e_mb, "R4 not before due", e_mb, 0);
    drv(0, 0, 0);
    chk(e_mb && !e_mv && beat_cnt_o == 0, "R4 missing beat", e_mb, 1);
    drv(0, 0, 0);
    finish_run();
  end
endmodule